// File: doc/BRIEF.md
# Open-Drain Line Repeater Channel

This block carries one open-drain line (data or clock) between two bus segments, called side A and side B. Each side gives the block a sampled line level (1 = high) and takes from it an active-high pull-down request. A low that an outside device drives on one side is copied to the other side. The block records which side started each low period. It never mistakes its own pull-down for a low from a device on the bus, so it cannot latch itself low. Clock stretching and arbitration pass through in both directions. Two instances make a full two-wire repeater.

The block is active only while `link_en` from a hot-swap connect controller is high. When `link_en` drops, both pull-downs are released in the same cycle and the record of the initiating side is cleared. Line levels first pass through a synchronizer that is `SYNC_STAGES` flops deep (0 means no synchronizer). After the block releases a pull-down, it waits `SYNC_STAGES+1` cycles before it trusts its inputs again. This wait covers the synchronizer delay, during which an input can still show the block's own low.

The state machine has five states:
- IDLE: no pull-downs on.
- A_LEAD: a device on A started the low; B is pulled down.
- B_LEAD: a device on B started the low; A is pulled down.
- B_HOLD: the device on B has let go; B is still held low by the block until A reads high.
- DRAIN: no pull-downs on; the guard wait runs.

The transitions are:
- IDLE→A_LEAD when A reads low, including when both sides read low.
- IDLE→B_LEAD when only B reads low.
- A_LEAD→DRAIN when A reads high.
- B_LEAD→B_HOLD when B reads high.
- B_HOLD→DRAIN when A reads high.
- DRAIN, once its guard wait has run out, moves the same way IDLE does, or to IDLE when both sides read high.
- Any state→IDLE when `link_en` is low.

Top module: `od_repeater_chan`

## Requirements
- R1: While connected, a low from a device on side A turns `b_pull` on, with `a_pull` off.
- R2: When side A is released and reads high again, `b_pull` turns off and both lines return high.
- R3: While connected, a low from a device on side B alone turns `a_pull` on, with `b_pull` off.
- R4: When the device on B lets go, `a_pull` turns off and `b_pull` turns on. `b_pull` stays on until A reads high, and then it turns off.
- R5: While `link_en` is 0, `a_pull` and `b_pull` are 0 in the same cycle, whatever the line levels. When the link is restored with both lines high, no pull-down is on.
- R6: If both sides read low in the same sample from idle, side A is taken as the initiator: `b_pull` is 1 and `a_pull` is 0.
- R7: The block never treats a low it drives itself as a low from a device on the bus. After any exchange, both pull-downs go off and both lines return high, and the block never drives both sides at once.
- R8: The record of the initiating side returns to idle only when both sides read high. If B is still held low by a device after an A-started low ends (clock stretch), `a_pull` turns on until B is released.
- R9: If a device on A holds A low during a B-started low (stretch or arbitration), B stays pulled down after the device on B lets go, until A is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Connect permission from the hot-swap controller |
| a_in | input | 1 | Side A line level, 1 = high |
| b_in | input | 1 | Side B line level, 1 = high |
| a_pull | output | 1 | Side A pull-down request, 1 = drive low |
| b_pull | output | 1 | Side B pull-down request, 1 = drive low |

## Verification
The bench models each line as a wired-AND of an outside driver and the block's own pull-down, and feeds that level back into the block. Four patterns are used: a low on A alone, a low on B alone, a low on both sides in the same sample, and overlapping lows where one side outlasts the other. The single-side lows separate the two copy directions. The same-sample low tests the initiator priority. The overlapping lows show whether stretching passes through and whether the block's own drive could hold a line low. A link drop in the middle of a low, and a reconnect while a line is still low, show that the pull-downs are released at once and that the initiator record is cleared.

// File: rtl/od_rptr_pkg.sv
package od_rptr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_A_LEAD = 3'd1,
        ST_B_LEAD = 3'd2,
        ST_B_HOLD = 3'd3,
        ST_DRAIN  = 3'd4
    } rptr_state_e;
endpackage

// File: rtl/od_rptr_sync.sv
module od_rptr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign line_out = line_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else if (STAGES == 1) begin
                    chain_q[0] <= line_in;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], line_in};
                end
            end
            assign line_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/od_rptr_fsm.sv
module od_rptr_fsm
    import od_rptr_pkg::*;
#(
    parameter int GUARD = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_en,
    input  logic        a_s,
    input  logic        b_s,
    output rptr_state_e state
);
    localparam int CW = $clog2(GUARD + 1);

    rptr_state_e state_d;
    logic [CW-1:0] guard_q, guard_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            guard_q <= '0;
        end else begin
            state   <= state_d;
            guard_q <= guard_d;
        end
    end

    always_comb begin
        state_d = state;
        guard_d = guard_q;
        if (!link_en) begin
            state_d = ST_IDLE;
            guard_d = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!a_s)      state_d = ST_A_LEAD;
                    else if (!b_s) state_d = ST_B_LEAD;
                end
                ST_A_LEAD: begin
                    if (a_s) begin
                        state_d = ST_DRAIN;
                        guard_d = CW'(GUARD);
                    end
                end
                ST_B_LEAD: begin
                    if (b_s) state_d = ST_B_HOLD;
                end
                ST_B_HOLD: begin
                    if (a_s) begin
                        state_d = ST_DRAIN;
                        guard_d = CW'(GUARD);
                    end
                end
                ST_DRAIN: begin
                    if (guard_q != '0) begin
                        guard_d = guard_q - 1'b1;
                    end else if (!a_s) begin
                        state_d = ST_A_LEAD;
                    end else if (!b_s) begin
                        state_d = ST_B_LEAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // R1: a low on A from idle makes A the initiator
    a_r1_a_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_IDLE && !a_s) |=> state == ST_A_LEAD);
    // R3: a low on B alone from idle makes B the initiator
    a_r3_b_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_IDLE && a_s && !b_s) |=> state == ST_B_LEAD);
    // R6: both low together resolves to A
    a_r6_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_IDLE && !a_s && !b_s) |=> state != ST_B_LEAD);
    // R4: B stays held while A still reads low
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_B_HOLD && !a_s) |=> state == ST_B_HOLD);
    // R5: a dropped link clears the direction record
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> state == ST_IDLE);
    // R7: inputs are ignored while the guard wait runs
    a_r7_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_DRAIN && guard_q != '0) |=> state == ST_DRAIN);
    // R8: no return to idle unless both sides read high
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state != ST_IDLE && !(a_s && b_s)) |=> state != ST_IDLE);
endmodule

// File: rtl/od_rptr_drive.sv
module od_rptr_drive
    import od_rptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_en,
    input  rptr_state_e state,
    output logic        a_pull,
    output logic        b_pull
);
    always_comb begin
        a_pull = 1'b0;
        b_pull = 1'b0;
        if (link_en) begin
            unique case (state)
                ST_IDLE:   ;
                ST_A_LEAD: b_pull = 1'b1;
                ST_B_LEAD: a_pull = 1'b1;
                ST_B_HOLD: b_pull = 1'b1;
                ST_DRAIN:  ;
                default:   ;
            endcase
        end
    end

    // R7: the two sides are never driven together
    a_r7_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pull && b_pull));
    // R2: leaving the A-led state drops the B pull-down
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && state == ST_DRAIN) |-> !b_pull && !a_pull);
endmodule

// File: rtl/od_repeater_chan.sv
module od_repeater_chan
    import od_rptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic a_in,
    input  logic b_in,
    output logic a_pull,
    output logic b_pull
);
    localparam int GUARD = SYNC_STAGES + 1;

    logic a_s, b_s;
    rptr_state_e state;

    od_rptr_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .line_in(a_in), .line_out(a_s));
    od_rptr_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .line_in(b_in), .line_out(b_s));

    od_rptr_fsm #(.GUARD(GUARD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .a_s(a_s), .b_s(b_s), .state(state));

    od_rptr_drive u_drive (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .state(state),
        .a_pull(a_pull), .b_pull(b_pull));
endmodule

// File: tb/od_repeater_chan_tb_top.sv
module od_repeater_chan_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_en = 1'b0;
    logic ext_a = 1'b0;
    logic ext_b = 1'b0;
    logic a_pull, b_pull;
    logic a_line, b_line;

    always #2.5 clk = ~clk;

    assign a_line = ~(ext_a | a_pull);
    assign b_line = ~(ext_b | b_pull);

    od_repeater_chan dut_i (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .a_in(a_line), .b_in(b_line),
        .a_pull(a_pull), .b_pull(b_pull));

    typedef struct {
        logic  ea;
        logic  eb;
        logic  xa;
        logic  xb;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    event chk_ev;

    task automatic step(input logic en, input logic xa_drv, input logic xb_drv,
                        input int waitc, input logic exp_a, input logic exp_b,
                        input string tag);
        exp_t e;
        @(negedge clk);
        link_en = en;
        ext_a = xa_drv;
        ext_b = xb_drv;
        repeat (waitc) @(negedge clk);
        #1;
        e.ea = xa_drv; e.eb = xb_drv; e.xa = exp_a; e.xb = exp_b; e.tag = tag;
        sb_q.push_back(e);
        ->chk_ev;
        #0.5;
    endtask

    initial begin : monitor
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                logic la, lb;
                e = sb_q.pop_front();
                la = ~(e.ea | e.xa);
                lb = ~(e.eb | e.xb);
                total++;
                if (a_pull !== e.xa || b_pull !== e.xb || a_line !== la || b_line !== lb) begin
                    bad++;
                    $display("FAIL %s: pulls a=%b b=%b lines a=%b b=%b, expected pulls a=%b b=%b lines a=%b b=%b",
                             e.tag, a_pull, b_pull, a_line, b_line, e.xa, e.xb, la, lb);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam int SETTLE = 12;

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (a_pull !== 1'b0 || b_pull !== 1'b0) begin
            bad++;
            $display("FAIL R5 reset: pulls a=%b b=%b expected 0 0", a_pull, b_pull);
        end
        rst_n = 1'b1;
        step(1, 0, 0, SETTLE, 0, 0, "R7 idle after reset");
        // A-started low and release
        step(1, 1, 0, SETTLE, 0, 1, "R1 A low copied to B");
        step(1, 0, 0, SETTLE, 0, 0, "R2 A release frees B");
        // B-started low and release
        step(1, 0, 1, SETTLE, 1, 0, "R3 B low copied to A");
        step(1, 0, 0, SETTLE, 0, 0, "R4 B release ends with both high");
        // A stretches during a B-led low
        step(1, 0, 1, SETTLE, 1, 0, "R3 B leads again");
        step(1, 1, 1, SETTLE, 1, 0, "R9 A joins, B still leads");
        step(1, 1, 0, SETTLE, 0, 1, "R4 R9 B held while A low");
        step(1, 0, 0, SETTLE, 0, 0, "R4 B freed once A high");
        // simultaneous low, then B stretches
        step(1, 1, 1, SETTLE, 0, 1, "R6 both low, A initiator");
        step(1, 0, 1, SETTLE, 1, 0, "R8 B stretch passed to A");
        step(1, 0, 0, SETTLE, 0, 0, "R8 stretch end, idle");
        // link drop mid-low
        step(1, 1, 0, SETTLE, 0, 1, "R1 A low before drop");
        step(0, 1, 0, 0, 0, 0, "R5 drop releases at once");
        step(0, 1, 1, SETTLE, 0, 0, "R5 lows ignored while down");
        step(0, 0, 0, SETTLE, 0, 0, "R5 lines high while down");
        step(1, 0, 0, SETTLE, 0, 0, "R5 reconnect idle");
        // reconnect while A still low
        step(0, 1, 0, SETTLE, 0, 0, "R5 A low while down");
        step(1, 1, 0, SETTLE, 0, 1, "R1 reconnect with A low");
        step(1, 0, 0, SETTLE, 0, 0, "R2 R7 final release");
        // repeated short A pulses
        for (int i = 0; i < 3; i++) begin
            step(1, 1, 0, SETTLE, 0, 1, "R1 pulse low");
            step(1, 0, 0, SETTLE, 0, 0, "R7 pulse release");
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule